// File: doc/BRIEF.md
# Digit-serial binary field multiplier, most significant digit first

This block multiplies two elements of GF(2^M) held in polynomial basis, where the field is fixed at build time by an irreducible polynomial of low weight (a trinomial or a pentanomial). A pulse on `start` loads the operands. The block then takes D bits of the first operand per clock, beginning with its highest digit. On each step the running product is multiplied by x^D and reduced modulo the field polynomial. The step also adds the sum of the shifted copies x^i·b mod f selected by the current digit.

Each shifted copy of `b` is reduced on its own, and the running sum never grows beyond M bits. The chain that forms the reduced copies of `b` is therefore a self-contained array that a wider datapath could share between several multipliers with a common operand. The first operand is zero-extended to the next multiple of D, so M need not divide evenly by the digit width. The default build is M = 239 with the polynomial x^239 + x^36 + 1 and a digit of 8 bits.

Top module: `gf2m_digit_mul`

## Requirements
- R1: After reset, `done` is 0 and `c` is all zeros.
- R2: A `start` sampled high while the block is idle captures `a` and `b` at that edge, and `c` reads zero in the following cycle. Later changes on `a` and `b` do not alter the product.
- R3: When `done` is high, `c` equals a·b reduced modulo the field polynomial. The polynomial is given by the parameter POLY, which holds the coefficients of x^0 to x^(M-1); x^M is implied.
- R4: If `start` is accepted at edge k, `done` is 0 through edge k+ceil(M/D)-1 and goes high after edge k+ceil(M/D). It stays high for exactly one cycle.
- R5: When M is not a multiple of D, the first operand is zero-extended at its top to ceil(M/D)·D bits, and the product is still exact.
- R6: A `start` pulse that arrives while a multiplication is in progress is ignored. The running product keeps its operands and delivers the original result at the usual time.
- R7: Once `done` has pulsed, `c` keeps the product unchanged until the next accepted `start`.
- R8: Trinomial and pentanomial field polynomials both give exact products. Examples are x^5+x^2+1 with D=2, and x^8+x^4+x^3+x+1 with D=3.
- R9: A `start` given in the same cycle that `done` is high is accepted. The next product follows with no idle cycle between the two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load operands and begin a multiplication (taken only when idle) |
| a | input | M | Multiplier operand, consumed digit by digit from the top |
| b | input | M | Multiplicand operand |
| done | output | 1 | One-cycle pulse when the product is ready |
| c | output | M | Product a·b mod f |

## Verification
A five-bit trinomial field with two-bit digits is swept over every pair of operands. This proves the Horner update, the reduction feedback and the zero padding of the odd top digit together. An eight-bit pentanomial field with three-bit digits is also run, with every first operand against a set of second operands. That set includes zero, one, x, the top bit and all ones; these values separate a wrong feedback tap, a digit taken in the wrong order and a dropped carry-out bit. Further runs inject a `start` in mid-computation, issue back-to-back starts on the `done` cycle, and vary the inputs while idle. These show that operands are latched once and that the product holds.

// File: rtl/gf2m_mul_pkg.sv
package gf2m_mul_pkg;

    // Number of D-bit digits needed to cover an M-bit operand.
    function automatic int num_digits(input int m, input int d);
        return (m + d - 1) / d;
    endfunction

endpackage

// File: rtl/gf2m_shift_reduce.sv
// One multiplication by x followed by reduction modulo the field polynomial.
module gf2m_shift_reduce #(
    parameter int          M    = 239,
    parameter logic [M-1:0] POLY = M'(1)
) (
    input  logic [M-1:0] v,
    output logic [M-1:0] vx
);
    always_comb begin
        vx = {v[M-2:0], 1'b0};
        if (v[M-1]) begin
            vx = vx ^ POLY;
        end
    end
endmodule

// File: rtl/gf2m_term_gen.sv
// Produces the reduced copies b, x*b, ..., x^(D-1)*b, each kept at M bits.
module gf2m_term_gen #(
    parameter int          M    = 239,
    parameter int          D    = 8,
    parameter logic [M-1:0] POLY = M'(1)
) (
    input  logic [M-1:0]        b,
    output logic [D-1:0][M-1:0] terms
);
    assign terms[0] = b;

    for (genvar i = 1; i < D; i++) begin : g_term
        gf2m_shift_reduce #(.M(M), .POLY(POLY)) u_sr (
            .v  (terms[i-1]),
            .vx (terms[i])
        );
    end
endmodule

// File: rtl/gf2m_xpow.sv
// Multiplies the accumulator by x^D modulo the field polynomial.
module gf2m_xpow #(
    parameter int          M    = 239,
    parameter int          D    = 8,
    parameter logic [M-1:0] POLY = M'(1)
) (
    input  logic [M-1:0] v,
    output logic [M-1:0] vxd
);
    logic [D:0][M-1:0] stage;

    assign stage[0] = v;

    for (genvar i = 0; i < D; i++) begin : g_stage
        gf2m_shift_reduce #(.M(M), .POLY(POLY)) u_sr (
            .v  (stage[i]),
            .vx (stage[i+1])
        );
    end

    assign vxd = stage[D];
endmodule

// File: rtl/gf2m_mul_ctrl.sv
// Sequencer: accepts start when idle, counts digits, pulses done.
module gf2m_mul_ctrl #(
    parameter int NDIG = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic done
);
    localparam int CW = $clog2(NDIG + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic          done;
    } ctrl_t;

    ctrl_t st_q, st_d;

    assign load = start && !st_q.busy;
    assign step = st_q.busy;
    assign done = st_q.done;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (load) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CW'(NDIG);
        end else if (st_q.busy) begin
            st_d.cnt = st_q.cnt - CW'(1);
            if (st_q.cnt == CW'(1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);

    // R4
    done_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.done) |-> $past(st_q.busy));

    // R6
    busy_not_reloaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt > CW'(1)) |=> (st_q.busy && st_q.cnt == $past(st_q.cnt) - CW'(1)));
endmodule

// File: rtl/gf2m_digit_mul.sv
module gf2m_digit_mul
    import gf2m_mul_pkg::*;
#(
    parameter int           M    = 239,
    parameter int           D    = 8,
    parameter logic [M-1:0] POLY = M'((1 << 36) | 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [M-1:0] a,
    input  logic [M-1:0] b,
    output logic         done,
    output logic [M-1:0] c
);
    localparam int NDIG = num_digits(M, D);
    localparam int N    = NDIG * D;

    typedef struct packed {
        logic [N-1:0] a;
        logic [M-1:0] b;
        logic [M-1:0] c;
    } dp_t;

    dp_t dp_q, dp_d;

    logic               load;
    logic               step;
    logic [D-1:0]       digit;
    logic [D-1:0][M-1:0] terms;
    logic [M-1:0]       c_shift;
    logic [M-1:0]       dsum;
    logic [N-1:0]       a_ext;

    gf2m_mul_ctrl #(.NDIG(NDIG)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .done  (done)
    );

    gf2m_term_gen #(.M(M), .D(D), .POLY(POLY)) u_terms (
        .b     (dp_q.b),
        .terms (terms)
    );

    gf2m_xpow #(.M(M), .D(D), .POLY(POLY)) u_xpow (
        .v   (dp_q.c),
        .vxd (c_shift)
    );

    assign digit = dp_q.a[N-1 -: D];

    always_comb begin
        a_ext        = '0;
        a_ext[M-1:0] = a;
    end

    always_comb begin
        dsum = '0;
        for (int i = 0; i < D; i++) begin
            if (digit[i]) begin
                dsum = dsum ^ terms[i];
            end
        end
    end

    always_comb begin
        dp_d = dp_q;
        if (load) begin
            dp_d.a = a_ext;
            dp_d.b = b;
            dp_d.c = '0;
        end else if (step) begin
            dp_d.a = dp_q.a << D;
            dp_d.c = c_shift ^ dsum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign c = dp_q.c;

    // R2
    clear_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (c == '0));

    // R7
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(c));

    // R2
    b_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> $stable(dp_q.b));

    if (N > M) begin : g_pad
        // R5
        pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            load |=> (dp_q.a[N-1:M] == '0));
    end
endmodule

// File: tb/tb_gf2m_digit_mul.sv
`timescale 1ns/1ps
module tb_gf2m_digit_mul;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic       st0 = 1'b0, st1 = 1'b0;
    logic [4:0] a0 = '0, b0 = '0, c0;
    logic [7:0] a1 = '0, b1 = '0, c1;
    logic       done0, done1;

    int nchk = 0;
    int nerr = 0;

    gf2m_digit_mul #(.M(5), .D(2), .POLY(5'h05)) dut (
        .clk(clk), .rst_n(rst_n), .start(st0), .a(a0), .b(b0), .done(done0), .c(c0)
    );

    gf2m_digit_mul #(.M(8), .D(3), .POLY(8'h1B)) dut_pent (
        .clk(clk), .rst_n(rst_n), .start(st1), .a(a1), .b(b1), .done(done1), .c(c1)
    );

    function automatic int fm(int sel);
        return (sel == 0) ? 5 : 8;
    endfunction

    function automatic logic [7:0] fpoly(int sel);
        return (sel == 0) ? 8'h05 : 8'h1B;
    endfunction

    function automatic logic [7:0] fmask(int sel);
        return (sel == 0) ? 8'h1F : 8'hFF;
    endfunction

    function automatic int fdig(int sel);
        return (fm(sel) + ((sel == 0) ? 2 : 3) - 1) / ((sel == 0) ? 2 : 3);
    endfunction

    function automatic logic [7:0] ref_mul(logic [7:0] x, logic [7:0] y, int m, logic [7:0] p);
        logic [8:0] r;
        r = '0;
        for (int i = m - 1; i >= 0; i--) begin
            r = r << 1;
            if (r[m]) r = r ^ (9'(1) << m) ^ {1'b0, p};
            if (x[i]) r = r ^ {1'b0, y};
        end
        return r[7:0];
    endfunction

    function automatic logic [7:0] get_c(int sel);
        return (sel == 0) ? {3'b000, c0} : c1;
    endfunction

    function automatic logic get_done(int sel);
        return (sel == 0) ? done0 : done1;
    endfunction

    task automatic drive(int sel, logic s, logic [7:0] x, logic [7:0] y);
        if (sel == 0) begin st0 = s; a0 = x[4:0]; b0 = y[4:0]; end
        else          begin st1 = s; a1 = x;      b1 = y;      end
    endtask

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Starts at a falling edge, returns at the falling edge where done is high.
    task automatic run_mul(int sel, logic [7:0] x, logic [7:0] y, bit inject, string tag);
        logic [7:0] exp;
        exp = ref_mul(x & fmask(sel), y & fmask(sel), fm(sel), fpoly(sel));
        drive(sel, 1'b1, x, y);
        @(negedge clk);
        drive(sel, 1'b0, ~x, ~y);           // R2: later inputs must not matter
        check("R2 clear", get_c(sel), 8'h00);
        for (int j = 1; j <= fdig(sel); j++) begin
            if (inject && j == 1) drive(sel, 1'b1, y ^ 8'h5A, x ^ 8'hA5);  // R6
            @(negedge clk);
            drive(sel, 1'b0, ~x, ~y);
            if (j < fdig(sel)) check("R4 early done", {7'b0, get_done(sel)}, 8'h00);
        end
        check("R4 done", {7'b0, get_done(sel)}, 8'h01);
        check(tag, get_c(sel), exp);
    endtask

    task automatic idle_check(int sel);
        logic [7:0] held;
        held = get_c(sel);
        @(negedge clk);
        check("R4 done width", {7'b0, get_done(sel)}, 8'h00);
        check("R7 hold", get_c(sel), held);
    endtask

    logic [7:0] blist [8] = '{8'h00, 8'h01, 8'h02, 8'h80, 8'hFF, 8'h53, 8'hCA, 8'h1B};

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done0", {7'b0, done0}, 8'h00);
        check("R1 c0", {3'b0, c0}, 8'h00);
        check("R1 done1", {7'b0, done1}, 8'h00);
        check("R1 c1", c1, 8'h00);

        // Exhaustive sweep, trinomial, M not a multiple of D
        for (int x = 0; x < 32; x++) begin
            for (int y = 0; y < 32; y++) begin
                run_mul(0, 8'(x), 8'(y), 1'b0, "R3 R5 trinomial");
                idle_check(0);
            end
        end

        // Pentanomial sweep
        for (int x = 0; x < 256; x++) begin
            for (int k = 0; k < 8; k++) begin
                run_mul(1, 8'(x), blist[k], 1'b0, "R8 R5 pentanomial");
                idle_check(1);
            end
        end

        // Start while busy is ignored
        for (int k = 0; k < 6; k++) begin
            run_mul(0, 8'(3 + 5 * k), 8'(29 - 4 * k), 1'b1, "R6 trinomial");
            idle_check(0);
            run_mul(1, 8'(17 + 37 * k), 8'(200 - 31 * k), 1'b1, "R6 pentanomial");
            idle_check(1);
        end

        // Back-to-back starts on the done cycle
        run_mul(0, 8'h13, 8'h0B, 1'b0, "R9 first");
        run_mul(0, 8'h1F, 8'h1E, 1'b0, "R9 second");
        run_mul(0, 8'h07, 8'h19, 1'b0, "R9 third");
        idle_check(0);
        run_mul(1, 8'hA7, 8'h3C, 1'b0, "R9 first pent");
        run_mul(1, 8'h5E, 8'hF1, 1'b0, "R9 second pent");
        idle_check(1);

        // Long idle with toggling inputs
        for (int k = 0; k < 5; k++) begin
            drive(0, 1'b0, 8'(k * 7), 8'(k * 3));
            drive(1, 1'b0, 8'(k * 41), 8'(k * 13));
            idle_check(0);
            check("R7 hold pent", c1, ref_mul(8'h5E, 8'hF1, 8, 8'h1B));
        end

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule